// File: doc/BRIEF.md
# Configurable IEEE Rounding Stage

This block takes a sign-magnitude significand that still carries extra precision bits below its least significant kept bit and rounds it to the kept width. The rounding direction is selected per operation by a two-bit mode input. All four IEEE modes are supported: nearest with ties to even (the default encoding), toward zero, toward plus infinity and toward minus infinity. The directed modes take the sign into account, so they act on the value and not only on the magnitude.

The result is registered once. Alongside the rounded significand the stage reports a carry-out and an inexact flag. A carry-out means the increment overflowed the kept width. In that case the significand output reads all zeros, and the surrounding arithmetic stage shifts it and adjusts the exponent. The block knows nothing about exponents, special values or format conversion.

Top module: `round_stage`

## Requirements
- R1: While `rst_n` is low at a rising edge of `clk`, the outputs are cleared on that edge: `sig_o` = 0, `carry_o` = 0, `inexact_o` = 0.
- R2: The outputs reflect the inputs sampled at the previous rising edge (one register of latency). Between edges they do not change when the inputs change.
- R3: In mode 2'b00 (nearest-even), extra bits below one half of a kept LSB are dropped, and extra bits above one half round the magnitude up by one.
- R4: In mode 2'b00, when the extra bits are exactly one half (top extra bit 1, all lower extra bits 0), the result is the neighbour whose kept LSB is 0.
- R5: In mode 2'b01 (toward zero), the extra bits are discarded and the magnitude is never incremented.
- R6: In mode 2'b10 (toward plus infinity), a positive value (`sign_i` = 0) with nonzero extra bits is incremented in magnitude, and a negative value keeps its magnitude.
- R7: In mode 2'b11 (toward minus infinity), a negative value (`sign_i` = 1) with nonzero extra bits is incremented in magnitude, and a positive value keeps its magnitude.
- R8: `inexact_o` is 1 exactly when any extra bit of the input was nonzero, in every mode.
- R9: When an increment overflows the kept width (kept bits all ones), `carry_o` is 1 and `sig_o` is 0. Otherwise `carry_o` is 0.
- R10: When all extra bits are zero, the kept bits pass through unchanged in every mode, with `carry_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| sign_i | input | 1 | Sign of the value, 1 = negative |
| sig_i | input | KEEP_W+EXTRA_W | Significand; the low EXTRA_W bits are the extra precision bits |
| mode_i | input | 2 | Rounding mode: 00 nearest-even, 01 toward zero, 10 toward +inf, 11 toward -inf |
| sig_o | output | KEEP_W | Rounded significand |
| carry_o | output | 1 | Increment overflowed the kept width |
| inexact_o | output | 1 | Some extra bit was nonzero |

## Verification
The bench sweeps every significand, sign and mode for a five-bit kept width, and computes the expected result from the integer quotient and remainder. The exact-halfway pattern is the main target. A design that rounds half up gives an odd result on ties, and one that ignores the tie gives the wrong neighbour. Sign handling in the directed modes is checked with both signs: a swapped or sign-blind decision moves negative values the wrong way. The all-ones significand checks that a rounding step which overflows raises the carry and returns zero rather than wrapping without notice. The bench also checks that the inexact flag follows the extra bits in every mode, including toward zero, where nothing is incremented.

// File: rtl/round_stage_pkg.sv
// Package: shared types for the rounding stage.
// Assumes: the mode encoding is fixed by the caller's two-bit select.
package round_stage_pkg;
    typedef enum logic [1:0] {
        RM_NEAREST_EVEN = 2'b00,
        RM_TO_ZERO      = 2'b01,
        RM_TO_POS       = 2'b10,
        RM_TO_NEG       = 2'b11
    } rmode_e;
endpackage

// File: rtl/rnd_split.sv
// Module: rnd_split
// Splits a significand into its kept part, the guard bit (top extra bit)
// and the sticky bit (OR of the remaining extra bits). It also flags inexact.
// Assumes: EXTRA_W >= 1.
module rnd_split #(
    parameter int KEEP_W  = 8,
    parameter int EXTRA_W = 2,
    localparam int W      = KEEP_W + EXTRA_W
) (
    input  logic [W-1:0]      sig_i,
    output logic [KEEP_W-1:0] kept_o,
    output logic              guard_o,
    output logic              sticky_o,
    output logic              inexact_o
);
    assign kept_o  = sig_i[W-1:EXTRA_W];
    assign guard_o = sig_i[EXTRA_W-1];

    // Sticky exists only when there is more than one extra bit.
    generate
        if (EXTRA_W > 1) begin : g_sticky
            assign sticky_o = |sig_i[EXTRA_W-2:0];
        end else begin : g_no_sticky
            assign sticky_o = 1'b0;
        end
    endgenerate

    assign inexact_o = guard_o | sticky_o;
endmodule

// File: rtl/rnd_decide.sv
// Module: rnd_decide
// Decides whether the kept magnitude is incremented, from the mode, the sign,
// the kept LSB and the guard and sticky bits.
// Assumes: guard and sticky are taken from the bits directly below the LSB.
module rnd_decide
    import round_stage_pkg::*;
(
    input  rmode_e mode_i,
    input  logic   sign_i,
    input  logic   lsb_i,
    input  logic   guard_i,
    input  logic   sticky_i,
    output logic   inc_o
);
    // Per-mode increment rule.
    always_comb begin
        unique case (mode_i)
            RM_NEAREST_EVEN: inc_o = guard_i & (sticky_i | lsb_i);
            RM_TO_ZERO:      inc_o = 1'b0;
            RM_TO_POS:       inc_o = ~sign_i & (guard_i | sticky_i);
            RM_TO_NEG:       inc_o =  sign_i & (guard_i | sticky_i);
            default:         inc_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/rnd_incr.sv
// Module: rnd_incr
// Adds a single increment bit to the kept significand through an explicit
// ripple carry chain and reports the carry out of the top bit.
// Assumes: WIDTH >= 1.
module rnd_incr #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] val_i,
    input  logic             inc_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             carry_o
);
    logic [WIDTH:0] chain;

    assign chain[0] = inc_i;

    // One half-adder cell per bit.
    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_cell
            assign sum_o[i]     = val_i[i] ^ chain[i];
            assign chain[i+1]   = val_i[i] & chain[i];
        end
    endgenerate

    assign carry_o = chain[WIDTH];
endmodule

// File: rtl/round_stage.sv
// Module: round_stage
// Rounds a sign-magnitude significand with EXTRA_W precision bits down to
// KEEP_W bits under one of four IEEE modes. The outputs are registered once.
// Assumes: the caller renormalises when carry_o is set (sig_o then reads 0).
module round_stage
    import round_stage_pkg::*;
#(
    parameter int KEEP_W  = 8,
    parameter int EXTRA_W = 2,
    localparam int W      = KEEP_W + EXTRA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sign_i,
    input  logic [W-1:0]      sig_i,
    input  logic [1:0]        mode_i,
    output logic [KEEP_W-1:0] sig_o,
    output logic              carry_o,
    output logic              inexact_o
);
    rmode_e            mode_w;
    logic [KEEP_W-1:0] kept_w;
    logic [KEEP_W-1:0] sum_w;
    logic              guard_w;
    logic              sticky_w;
    logic              inexact_w;
    logic              inc_w;
    logic              cout_w;

    assign mode_w = rmode_e'(mode_i);

    rnd_split #(.KEEP_W(KEEP_W), .EXTRA_W(EXTRA_W)) split_i (
        .sig_i     (sig_i),
        .kept_o    (kept_w),
        .guard_o   (guard_w),
        .sticky_o  (sticky_w),
        .inexact_o (inexact_w)
    );

    rnd_decide decide_i (
        .mode_i   (mode_w),
        .sign_i   (sign_i),
        .lsb_i    (kept_w[0]),
        .guard_i  (guard_w),
        .sticky_i (sticky_w),
        .inc_o    (inc_w)
    );

    rnd_incr #(.WIDTH(KEEP_W)) incr_i (
        .val_i   (kept_w),
        .inc_i   (inc_w),
        .sum_o   (sum_w),
        .carry_o (cout_w)
    );

    // Output register with synchronous active-low clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sig_o     <= '0;
            carry_o   <= 1'b0;
            inexact_o <= 1'b0;
        end else begin
            sig_o     <= sum_w;
            carry_o   <= cout_w;
            inexact_o <= inexact_w;
        end
    end

    // R1: reset clears every output.
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (sig_o == '0 && !carry_o && !inexact_o));

    // R9: an overflowing increment leaves the kept bits at zero.
    p_carry_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        carry_o |-> (sig_o == '0));

    // R10: exact inputs pass through unchanged.
    p_exact_pass_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(sig_i[EXTRA_W-1:0]) == '0)
        |-> (sig_o == $past(sig_i[W-1:EXTRA_W]) && !carry_o && !inexact_o));

    // R5: toward zero never increments.
    p_to_zero_noinc_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(mode_i) == 2'b01)
        |-> (sig_o == $past(sig_i[W-1:EXTRA_W]) && !carry_o));

    // R6: toward +inf keeps the magnitude of negative values.
    p_to_pos_neg_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(mode_i) == 2'b10 && $past(sign_i))
        |-> (sig_o == $past(sig_i[W-1:EXTRA_W]) && !carry_o));

    // R7: toward -inf keeps the magnitude of positive values.
    p_to_neg_pos_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(mode_i) == 2'b11 && !$past(sign_i))
        |-> (sig_o == $past(sig_i[W-1:EXTRA_W]) && !carry_o));

    // R8: inexact follows the extra bits in every mode.
    p_inexact_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (inexact_o == ($past(sig_i[EXTRA_W-1:0]) != '0)));
endmodule

// File: tb/round_stage_tb.sv
`timescale 1ns/1ps
// Bench: exhaustive sweep of significand, sign and mode for a small width.
module round_stage_tb_top;
    localparam int K = 5;
    localparam int E = 2;
    localparam int W = K + E;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         sign_i = 1'b0;
    logic [W-1:0] sig_i = '0;
    logic [1:0]   mode_i = 2'b00;
    logic [K-1:0] sig_o;
    logic         carry_o;
    logic         inexact_o;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    round_stage #(.KEEP_W(K), .EXTRA_W(E)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .sign_i    (sign_i),
        .sig_i     (sig_i),
        .mode_i    (mode_i),
        .sig_o     (sig_o),
        .carry_o   (carry_o),
        .inexact_o (inexact_o)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d (sign=%0d sig=%0d mode=%0d)",
                     req, act, exp, sign_i, sig_i, mode_i);
        end
    endtask

    // Stimulus and checks.
    initial begin
        // R1: reset clears outputs even with active inputs.
        sign_i = 1'b0; sig_i = '1; mode_i = 2'b10;
        repeat (3) @(negedge clk);
        check("R1 sig", int'(sig_o), 0);
        check("R1 carry", int'(carry_o), 0);
        check("R1 inexact", int'(inexact_o), 0);
        @(negedge clk) rst_n = 1'b1;

        for (int m = 0; m < 4; m++) begin
            for (int sg = 0; sg < 2; sg++) begin
                for (int s = 0; s < (1 << W); s++) begin
                    int scale, lo, rem, half, inc, res, exp_sig, exp_c;
                    string tag;
                    @(negedge clk);
                    sign_i = sg[0]; sig_i = W'(s); mode_i = m[1:0];
                    scale = 1 << E; lo = s / scale; rem = s % scale; half = scale / 2;
                    inc = 0;
                    case (m)
                        0: inc = (rem > half || (rem == half && (lo % 2) == 1)) ? 1 : 0;
                        1: inc = 0;
                        2: inc = (sg == 0 && rem != 0) ? 1 : 0;
                        default: inc = (sg == 1 && rem != 0) ? 1 : 0;
                    endcase
                    res = lo + inc;
                    exp_c = (res >= (1 << K)) ? 1 : 0;
                    exp_sig = res % (1 << K);
                    if (rem == 0) tag = "R10";
                    else if (exp_c == 1) tag = "R9";
                    else if (m == 0) tag = (rem == half) ? "R4" : "R3";
                    else if (m == 1) tag = "R5";
                    else if (m == 2) tag = "R6";
                    else tag = "R7";
                    @(negedge clk);
                    check({tag, " sig"}, int'(sig_o), exp_sig);
                    check({tag, " carry"}, int'(carry_o), exp_c);
                    check("R8 inexact", int'(inexact_o), (rem != 0) ? 1 : 0);
                end
            end
        end

        // R2: output holds between edges while the inputs change.
        @(negedge clk);
        sign_i = 1'b0; sig_i = W'(4 * 9 + 3); mode_i = 2'b00;
        @(negedge clk);
        check("R2 settled", int'(sig_o), 10);
        sig_i = W'(4 * 20);
        #1;
        check("R2 hold", int'(sig_o), 10);
        @(negedge clk);
        check("R2 next", int'(sig_o), 20);

        // R1: mid-run reset clears outputs.
        sig_i = '1; mode_i = 2'b10; rst_n = 1'b0;
        @(negedge clk);
        check("R1 mid sig", int'(sig_o), 0);
        check("R1 mid carry", int'(carry_o), 0);
        rst_n = 1'b1;

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(5ns * 100000);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end
endmodule